// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command-register state machine of an 8-bit parallel NOR flash device. It watches the write strobe of the host bus and takes each write cycle's address and data when the strobe is released (its rising edge). Multi-cycle unlock sequences move it between normal array reads, an identifier overlay, and the path that starts a full-chip erase. Any write that does not fit the expected sequence sends it back to normal reads, and no operation starts.

While the identifier overlay is active, reads return fixed codes instead of array data. The two lowest address bits choose the code: manufacturer, device, or the protection state of the addressed sector. The protection state arrives as a single input bit. When the six-cycle chip-erase sequence completes, the block sends a one-cycle start pulse to an external erase engine. While that engine reports busy, every command write is ignored except one: a reset written while the engine also reports failure is accepted and produces an abort pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `id_mode`, `erase_start` and `erase_abort` are 0, and `rdata` equals `array_rdata`.
- R2: In read mode, `rdata` follows `array_rdata` on every read. The mode lasts until another command write changes it.
- R3: Three writes, AAh at command address 555h, then 55h at 2AAh, then 90h at 555h, set `id_mode` to 1. In that mode a read with addr[1:0]=00 returns C2h. The command address is addr[10:0], and higher address bits are ignored.
- R4: In identifier mode a read with addr[1:0]=01 returns A4h.
- R5: In identifier mode a read with addr[1]=1 returns 01h when `sect_prot`=1 and 00h when `sect_prot`=0.
- R6: A write of F0h at any address returns the block to read mode (`id_mode`=0, `rdata`=`array_rdata`).
- R7: Six writes start a chip erase: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. `erase_start` is high for exactly one clock cycle, and that cycle follows the clock edge that samples the last strobe's rising edge. Afterwards the block is in read mode.
- R8: A write whose data or address does not match the next expected step returns the block to read mode, and no erase starts. Finishing the remaining steps afterwards starts nothing.
- R9: While `erase_busy`=1, command writes do not change the mode and never produce `erase_start`.
- R10: While `erase_busy`=1 and `erase_fail`=1, a write of F0h produces a one-cycle `erase_abort` pulse and selects read mode. With `erase_fail`=0 the same write produces no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we_n | input | 1 | Write strobe, active low. A command is taken at its rising edge |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Write data |
| array_rdata | input | 8 | Data read from the memory array |
| sect_prot | input | 1 | Protection state of the addressed sector |
| erase_busy | input | 1 | Erase engine is running |
| erase_fail | input | 1 | Erase engine has reported a failure |
| rdata | output | 8 | Read data: array data or an identifier code |
| id_mode | output | 1 | Identifier overlay is active |
| erase_start | output | 1 | One-cycle pulse that starts a chip erase |
| erase_abort | output | 1 | One-cycle pulse that aborts a failed erase |

## Verification
A wrong sequencer state reaches the ports within one clock cycle of the strobe that caused it. A missed or spurious identifier entry shows up at once on `rdata`: the next read after the command returns C2h in place of array data, or array data in place of C2h. A wrong erase-path state shows up only at the sixth write: the start pulse is missing, or it fires after a broken sequence. For that reason the directed tests break the sequence at several steps and then finish it. A busy-gating fault shows up as a change of mode, or as a start or abort pulse, one cycle after a write made while the engine is busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int CMD_AW  = 11;

    localparam logic [CMD_AW-1:0] ADR_FIRST  = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] OP_IDENT   = 8'h90;
    localparam logic [BYTE_W-1:0] OP_ESETUP  = 8'h80;
    localparam logic [BYTE_W-1:0] OP_ECHIP   = 8'h10;
    localparam logic [BYTE_W-1:0] OP_RESET   = 8'hF0;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_IDENT,
        ST_ESET,
        ST_EUL1,
        ST_EUL2
    } seq_state_t;

    typedef struct packed {
        seq_state_t st;
        logic       start;
        logic       abort;
    } seq_reg_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic commit
);
    logic we_d, we_q;

    always_comb begin
        we_d   = we_n;
        commit = we_n && !we_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_d;
    end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              erase_busy,
    input  logic              erase_fail,
    output logic              id_mode,
    output logic              erase_start,
    output logic              erase_abort
);
    seq_reg_t r_d, r_q;
    logic [CMD_AW-1:0] cmd_addr;
    logic at_first, at_second, key1, key2, is_reset;

    always_comb begin
        cmd_addr  = addr[CMD_AW-1:0];
        at_first  = (cmd_addr == ADR_FIRST);
        at_second = (cmd_addr == ADR_SECOND);
        key1      = at_first  && (wdata == KEY_FIRST);
        key2      = at_second && (wdata == KEY_SECOND);
        is_reset  = (wdata == OP_RESET);

        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.abort = 1'b0;

        if (commit) begin
            if (erase_busy) begin
                if (erase_fail && is_reset) begin
                    r_d.abort = 1'b1;
                    r_d.st    = ST_READ;
                end
            end else if (is_reset) begin
                r_d.st = ST_READ;
            end else begin
                case (r_q.st)
                    ST_READ, ST_IDENT: r_d.st = key1 ? ST_UL1 : ST_READ;
                    ST_UL1:            r_d.st = key2 ? ST_UL2 : ST_READ;
                    ST_UL2: begin
                        if (at_first && wdata == OP_IDENT)       r_d.st = ST_IDENT;
                        else if (at_first && wdata == OP_ESETUP) r_d.st = ST_ESET;
                        else                                     r_d.st = ST_READ;
                    end
                    ST_ESET:           r_d.st = key1 ? ST_EUL1 : ST_READ;
                    ST_EUL1:           r_d.st = key2 ? ST_EUL2 : ST_READ;
                    ST_EUL2: begin
                        r_d.st    = ST_READ;
                        r_d.start = at_first && (wdata == OP_ECHIP);
                    end
                    default:           r_d.st = ST_READ;
                endcase
            end
        end

        id_mode     = (r_q.st == ST_IDENT);
        erase_start = r_q.start;
        erase_abort = r_q.abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_READ;
            r_q.start <= 1'b0;
            r_q.abort <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/id_overlay.sv
module id_overlay
    import flash_cmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'hC2,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'hA4
) (
    input  logic              id_mode,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] array_rdata,
    input  logic              sect_prot,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] code;

    always_comb begin
        if (sel[1])      code = {{(BYTE_W-1){1'b0}}, sect_prot};
        else if (sel[0]) code = DEV_CODE;
        else             code = MFR_CODE;
        rdata = id_mode ? code : array_rdata;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        array_rdata,
    input  logic              sect_prot,
    input  logic              erase_busy,
    input  logic              erase_fail,
    output logic [7:0]        rdata,
    output logic              id_mode,
    output logic              erase_start,
    output logic              erase_abort
);
    logic commit;

    strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_n   (we_n),
        .commit (commit)
    );

    cmd_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .addr        (addr),
        .wdata       (wdata),
        .erase_busy  (erase_busy),
        .erase_fail  (erase_fail),
        .id_mode     (id_mode),
        .erase_start (erase_start),
        .erase_abort (erase_abort)
    );

    id_overlay u_ovl (
        .id_mode     (id_mode),
        .sel         (addr[1:0]),
        .array_rdata (array_rdata),
        .sect_prot   (sect_prot),
        .rdata       (rdata)
    );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        array_rdata,
    input logic              sect_prot,
    input logic              erase_busy,
    input logic              erase_fail,
    input logic [7:0]        rdata,
    input logic              id_mode,
    input logic              erase_start,
    input logic              erase_abort
);
    // R2
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rdata == array_rdata);

    // R5
    prot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr[1]) |-> rdata == {7'b0, sect_prot});

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R7
    start_read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> !id_mode);

    // R9
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && !erase_fail) |=> ($stable(id_mode) && !erase_start && !erase_abort));

    // R10
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |-> $past(erase_busy && erase_fail));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .array_rdata (array_rdata),
    .sect_prot   (sect_prot),
    .erase_busy  (erase_busy),
    .erase_fail  (erase_fail),
    .rdata       (rdata),
    .id_mode     (id_mode),
    .erase_start (erase_start),
    .erase_abort (erase_abort)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    array_rdata = 8'h00;
    logic          sect_prot = 1'b0;
    logic          erase_busy = 1'b0;
    logic          erase_fail = 1'b0;
    logic [7:0]    rdata;
    logic          id_mode;
    logic          erase_start;
    logic          erase_abort;

    int n_checks = 0;
    int n_errors = 0;
    int starts = 0;
    int aborts = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .array_rdata(array_rdata), .sect_prot(sect_prot),
        .erase_busy(erase_busy), .erase_fail(erase_fail),
        .rdata(rdata), .id_mode(id_mode),
        .erase_start(erase_start), .erase_abort(erase_abort)
    );

    always @(posedge clk) begin
        if (erase_start) starts++;
        if (erase_abort) aborts++;
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // strobe low one cycle, release; returns at the negedge after the sampling edge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_at(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic enter_id();
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        wr(19'h555, 8'h90);
    endtask

    task automatic t_reset();
        check("R1", "id_mode", id_mode, 0);
        check("R1", "erase_start", erase_start, 0);
        check("R1", "erase_abort", erase_abort, 0);
        array_rdata = 8'h3C; #1;
        check("R1", "rdata", rdata, 8'h3C);
    endtask

    task automatic t_read();
        array_rdata = 8'h5A; read_at(19'h00010);
        check("R2", "rdata first", rdata, 8'h5A);
        array_rdata = 8'hC3; read_at(19'h00000);
        check("R2", "rdata second", rdata, 8'hC3);
        check("R2", "id_mode", id_mode, 0);
    endtask

    task automatic t_ident();
        enter_id();
        check("R3", "id_mode", id_mode, 1);
        array_rdata = 8'h77;
        read_at(19'h00000); check("R3", "manufacturer", rdata, 8'hC2);
        read_at(19'h40000); check("R3", "manufacturer upper bits", rdata, 8'hC2);
        read_at(19'h00001); check("R4", "device", rdata, 8'hA4);
        sect_prot = 1'b0; read_at(19'h00002); check("R5", "unprotected", rdata, 8'h00);
        sect_prot = 1'b1; read_at(19'h00002); check("R5", "protected", rdata, 8'h01);
        read_at(19'h10003); check("R5", "protected a0=1", rdata, 8'h01);
        sect_prot = 1'b0;
    endtask

    task automatic t_reset_cmd();
        wr(19'h01234, 8'hF0);
        check("R6", "id_mode", id_mode, 0);
        array_rdata = 8'h19; read_at(19'h00000);
        check("R6", "rdata", rdata, 8'h19);
    endtask

    task automatic t_erase();
        int s0 = starts;
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        wr(19'h555, 8'h80);
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        check("R7", "no start before last", starts - s0, 0);
        wr(19'h555, 8'h10);
        check("R7", "erase_start pulse", erase_start, 1);
        @(negedge clk);
        check("R7", "erase_start drop", erase_start, 0);
        check("R7", "one pulse", starts - s0, 1);
        check("R7", "read mode after", id_mode, 0);
    endtask

    task automatic t_break();
        int s0 = starts;
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        wr(19'h555, 8'h80);
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h77);
        wr(19'h555, 8'h10);
        check("R8", "broken erase no start", starts - s0, 0);
        wr(19'h555, 8'hAA);
        wr(19'h2AB, 8'h55);
        wr(19'h555, 8'h90);
        check("R8", "wrong address no id", id_mode, 0);
        wr(19'h555, 8'hAA);
        wr(19'h555, 8'h90);
        check("R8", "skipped step no id", id_mode, 0);
        enter_id();
        check("R8", "recovery to id", id_mode, 1);
        wr(19'h00000, 8'hF0);
    endtask

    task automatic t_busy();
        int s0 = starts;
        int a0 = aborts;
        erase_busy = 1'b1;
        enter_id();
        check("R9", "id ignored while busy", id_mode, 0);
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        wr(19'h555, 8'h80);
        wr(19'h555, 8'hAA);
        wr(19'h2AA, 8'h55);
        wr(19'h555, 8'h10);
        check("R9", "no start while busy", starts - s0, 0);
        wr(19'h00000, 8'hF0);
        check("R10", "no abort without fail", aborts - a0, 0);
        erase_fail = 1'b1;
        wr(19'h00000, 8'hF0);
        check("R10", "abort pulse", erase_abort, 1);
        @(negedge clk);
        check("R10", "abort drop", erase_abort, 0);
        check("R10", "one abort", aborts - a0, 1);
        check("R10", "read mode", id_mode, 0);
        erase_fail = 1'b0;
        erase_busy = 1'b0;
    endtask

    initial begin
        #5000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read();
        t_ident();
        t_reset_cmd();
        t_erase();
        t_break();
        t_busy();
        enter_id();
        check("R3", "id after busy cleared", id_mode, 1);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule